// File: doc/BRIEF.md
# Borrow-lookahead magnitude comparator

This block compares two unsigned vectors of equal width and raises exactly one of three flags: equal, first operand greater, or first operand smaller. It is purely combinational. There are no registers, no clock and no reset. Its outputs settle within a fixed number of logic levels, and that number does not depend on the operand width.

The greater-than decision does not form a difference word. The block takes the operands as a subtraction of the first operand from the second. From each bit pair it derives a borrow-generate term and a borrow-propagate term, with the propagate built as an OR. These terms are folded into group functions over fixed-size groups. The group functions are then combined into one borrow-out in a single sum-of-products level. Equality is computed separately from grouped XOR reductions. The less-than flag is whatever is left when neither of the other two flags is high.

Top module: `mag_cmp_bla`

## Requirements
- R1: `gt_o` is 1 exactly when `a_in` is greater than `b_in`, both read as unsigned binary numbers.
- R2: `eq_o` is 1 exactly when every bit of `a_in` matches the bit in the same position of `b_in`.
- R3: `lt_o` is 1 exactly when `a_in` is less than `b_in` as unsigned numbers, and it equals NOT(`eq_o` OR `gt_o`).
- R4: For every input pair, exactly one of `eq_o`, `gt_o`, `lt_o` is 1.
- R5: The ordering result is the same for any borrow group size `GRP_W` (2, 3 or 4), including widths that are not a multiple of the group size. Unused upper group bits act as equal zero bits.
- R6: The equality result is the same for any XOR group size `EQ_GRP_W`, including widths that are not a multiple of it.
- R7: Operands that differ only in bit 0 are ordered by that bit. Operands that differ only in the most significant bit are ordered by that bit.
- R8: All-zero against all-ones, and each extreme against itself, give the correct single flag.
- R9: The default configuration is 12-bit operands, 2-bit borrow groups and 4-bit equality groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| eq_o | output | 1 | Operands are identical |
| gt_o | output | 1 | First operand is larger |
| lt_o | output | 1 | First operand is smaller |

## Verification
The hardest case to reach is a borrow that is generated in the lowest group and must pass through every higher group's propagate term. That happens only when the operands agree in all upper bits and differ in a low bit. Random operands almost never produce it. To cover it, small widths are swept exhaustively over every operand pair, with instances that use different group sizes, including one whose top group is only partly filled. The 12-bit instances are driven with directed vectors that differ in a single bit at bit 0, at each group boundary and at the MSB, and with a pseudo-random stream on top of those.

// File: rtl/mag_cmp_bla.sv
module mag_cmp_bla #(
  parameter int WIDTH    = 12,
  parameter int GRP_W    = 2,
  parameter int EQ_GRP_W = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic             eq_o,
  output logic             gt_o,
  output logic             lt_o
);

  localparam int NGRP   = (WIDTH + GRP_W - 1) / GRP_W;
  localparam int PAD_W  = NGRP * GRP_W;
  localparam int NEQ    = (WIDTH + EQ_GRP_W - 1) / EQ_GRP_W;
  localparam int EQPAD  = NEQ * EQ_GRP_W;

  logic [PAD_W-1:0] a_pad, b_pad, bit_gen, bit_prop;
  logic [NGRP-1:0]  grp_gen, grp_prop;
  logic [EQPAD-1:0] a_eqp, b_eqp;
  logic [NEQ-1:0]   grp_diff;
  logic             borrow_out;

  assign a_pad    = PAD_W'(a_in);
  assign b_pad    = PAD_W'(b_in);
  assign bit_gen  = a_pad & ~b_pad;
  assign bit_prop = a_pad | ~b_pad;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    always_comb begin
      logic gg, pp;
      gg = 1'b0;
      pp = 1'b1;
      for (int j = 0; j < GRP_W; j++) begin
        gg = bit_gen[k*GRP_W+j] | (bit_prop[k*GRP_W+j] & gg);
        pp = pp & bit_prop[k*GRP_W+j];
      end
      grp_gen[k]  = gg;
      grp_prop[k] = pp;
    end
  end

  always_comb begin
    logic term;
    borrow_out = 1'b0;
    for (int k = 0; k < NGRP; k++) begin
      term = grp_gen[k];
      for (int j = k + 1; j < NGRP; j++) term = term & grp_prop[j];
      borrow_out = borrow_out | term;
    end
  end

  assign a_eqp = EQPAD'(a_in);
  assign b_eqp = EQPAD'(b_in);

  for (genvar q = 0; q < NEQ; q++) begin : g_eq
    assign grp_diff[q] = |(a_eqp[q*EQ_GRP_W +: EQ_GRP_W] ^ b_eqp[q*EQ_GRP_W +: EQ_GRP_W]);
  end

  assign eq_o = ~|grp_diff;
  assign gt_o = borrow_out;
  assign lt_o = ~(eq_o | gt_o);

endmodule

module mag_cmp_bla_chk #(
  parameter int WIDTH = 12
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             eq_o,
  input logic             gt_o,
  input logic             lt_o
);

  always_comb begin
    if (!$isunknown({a_in, b_in, eq_o, gt_o, lt_o})) begin
      AST_ONE_FLAG: assert ($countones({eq_o, gt_o, lt_o}) == 1) else $error("flags not one-hot"); // R4
      AST_GT_ORDER: assert (gt_o == (a_in > b_in)) else $error("gt wrong"); // R1
      AST_EQ_MATCH: assert (eq_o == (a_in == b_in)) else $error("eq wrong"); // R2
      AST_LT_ORDER: assert (lt_o == (a_in < b_in)) else $error("lt wrong"); // R3
      AST_EQ_NOT_GT: assert (!(eq_o && gt_o)) else $error("eq and gt together"); // R4
    end
  end

endmodule

bind mag_cmp_bla mag_cmp_bla_chk #(.WIDTH(WIDTH)) u_chk (
  .a_in(a_in), .b_in(b_in), .eq_o(eq_o), .gt_o(gt_o), .lt_o(lt_o)
);

// File: tb/mag_cmp_bla_tb.sv
module mag_cmp_bla_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [11:0] a12, b12;
  logic [5:0]  a6, b6;
  logic [2:0]  eq12, gt12, lt12;
  logic [1:0]  eq6, gt6, lt6;

  mag_cmp_bla u_dut (.a_in(a12), .b_in(b12), .eq_o(eq12[0]), .gt_o(gt12[0]), .lt_o(lt12[0]));
  mag_cmp_bla #(.WIDTH(12), .GRP_W(3), .EQ_GRP_W(5)) u_dut_g3 (
    .a_in(a12), .b_in(b12), .eq_o(eq12[1]), .gt_o(gt12[1]), .lt_o(lt12[1]));
  mag_cmp_bla #(.WIDTH(12), .GRP_W(4), .EQ_GRP_W(3)) u_dut_g4 (
    .a_in(a12), .b_in(b12), .eq_o(eq12[2]), .gt_o(gt12[2]), .lt_o(lt12[2]));
  mag_cmp_bla #(.WIDTH(6), .GRP_W(2), .EQ_GRP_W(4)) u_small_g2 (
    .a_in(a6), .b_in(b6), .eq_o(eq6[0]), .gt_o(gt6[0]), .lt_o(lt6[0]));
  mag_cmp_bla #(.WIDTH(6), .GRP_W(4), .EQ_GRP_W(5)) u_small_g4 (
    .a_in(a6), .b_in(b6), .eq_o(eq6[1]), .gt_o(gt6[1]), .lt_o(lt6[1]));

  task automatic check(input string req, input logic got, input logic exp, input int aa, input int bb);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%0h b=%0h got=%b exp=%b", req, aa, bb, got, exp);
    end
  endtask

  task automatic chk_flags(input string tag, input logic e, input logic g, input logic l,
                           input int aa, input int bb);
    check({tag, " R2 eq"}, e, aa == bb, aa, bb);
    check({tag, " R1 gt"}, g, aa > bb, aa, bb);
    check({tag, " R3 lt"}, l, aa < bb, aa, bb);
    check({tag, " R4 one-hot"}, ($countones({e, g, l}) == 1), 1'b1, aa, bb);
  endtask

  task automatic run12(input logic [11:0] x, input logic [11:0] y, input string tag);
    @(negedge clk);
    a12 = x; b12 = y;
    @(posedge clk); #1;
    chk_flags({tag, " R9 g2"}, eq12[0], gt12[0], lt12[0], int'(x), int'(y));
    chk_flags({tag, " R5 g3"}, eq12[1], gt12[1], lt12[1], int'(x), int'(y));
    chk_flags({tag, " R6 g4"}, eq12[2], gt12[2], lt12[2], int'(x), int'(y));
  endtask

  initial begin
    logic [11:0] lfsr;
    a12 = '0; b12 = '0; a6 = '0; b6 = '0;
    @(posedge clk); #1;
    check("R2 reset-state eq", eq12[0], 1'b1, 0, 0);
    // R8 extremes
    run12(12'h000, 12'h000, "R8 zero");
    run12(12'hFFF, 12'hFFF, "R8 ones");
    run12(12'h000, 12'hFFF, "R8 zero-vs-ones");
    run12(12'hFFF, 12'h000, "R8 ones-vs-zero");
    // R7 single-bit differences at every position
    for (int i = 0; i < 12; i++) begin
      run12(12'h5A3 | (12'h1 << i), 12'h5A3 & ~(12'h1 << i), "R7 single-bit");
      run12(12'h5A3 & ~(12'h1 << i), 12'h5A3 | (12'h1 << i), "R7 single-bit");
    end
    run12(12'h001, 12'h000, "R7 lsb");
    run12(12'h7FF, 12'h800, "R7 msb");
    run12(12'h800, 12'h7FF, "R7 msb");
    lfsr = 12'hACE;
    for (int n = 0; n < 1500; n++) begin
      logic [11:0] x;
      lfsr = {lfsr[10:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]};
      x = lfsr;
      lfsr = {lfsr[10:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]};
      run12(x, (n % 4 == 0) ? x : lfsr, "R1 random");
    end
    // R5 R6 exhaustive sweep at 6 bits, full and partly filled groups
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 64; j++) begin
        @(negedge clk);
        a6 = 6'(i); b6 = 6'(j);
        @(posedge clk); #1;
        chk_flags("R5 small g2", eq6[0], gt6[0], lt6[0], i, j);
        chk_flags("R5 R6 small g4", eq6[1], gt6[1], lt6[1], i, j);
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule